// File: doc/BRIEF.md
# Sample-Hold Conversion Scheduler

This block runs an external 8-bit successive approximation converter with a sample-and-hold amplifier in front of it, and it repeats the process for as long as it is enabled. It drives a start pulse of a fixed minimum width and waits for the converter to raise its busy/ready line. It follows that line to switch the sample-and-hold between hold and sample. When the converter signals completion, the block reads the result with an active-low read enable. It then waits a full acquisition period, so the amplifier can track the input again, before it starts the next conversion.

The pace comes from the converter's own handshake, not from a free-running timer. The block has two failure checks. The first fires when the ready line does not rise within a start window. The second fires when a conversion runs longer than a maximum cycle count. Either one sets a sticky error flag. The block then waits one acquisition period from the point where the ready line is low and tries again. When enable is dropped, the block finishes the conversion in progress and then goes idle. All inputs are assumed to be synchronous to `clk_i`.

Top module: `conv_sched`

## Requirements
- R1: Each start pulse on `convert_o` stays high for exactly CONV_W consecutive cycles.
- R2: `hold_o` equals the value of `drdy_i` sampled at the previous clock edge (1 = hold, 0 = sample). It is 0 after reset.
- R3: `rd_en_no` goes low in the cycle after the clock edge that first samples `drdy_i` low at the end of a conversion. It stays low for exactly READ_W cycles and is never low while `convert_o` is high.
- R4: `result_o` takes the value of `data_i` from the last read-enable-low cycle. `result_valid_o` is high for exactly one cycle, which is the cycle in which `rd_en_no` returns high.
- R5: In continuous operation, `convert_o` rises exactly ACQ_W cycles after the clock edge that first samples `drdy_i` low.
- R6: If `drdy_i` is not seen high within DR_WIN cycles of the start pulse's rising edge, `error_o` rises DR_WIN cycles after that edge. A new start pulse follows ACQ_W cycles later while enabled.
- R7: If `drdy_i` stays high past MAX_W cycles from the start pulse's rising edge, `error_o` rises MAX_W cycles after that edge. No result is read for that attempt. A retry is allowed only ACQ_W cycles after `drdy_i` is low.
- R8: Once set, `error_o` stays high until `rst_ni` is asserted. Reset clears it.
- R9: While `enable_i` is high, conversions repeat. When `enable_i` goes low, a conversion in progress is completed and its result delivered, and no further start pulse is issued.
- R10: During reset: `convert_o`=0, `hold_o`=0, `rd_en_no`=1, `result_valid_o`=0, `error_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run continuous conversions |
| drdy_i | input | 1 | Converter ready line: high while converting, falls when done |
| data_i | input | DW | Converter result bus, valid while read enable is low |
| convert_o | output | 1 | Start pulse to the converter |
| hold_o | output | 1 | Sample-and-hold control, 1 = hold |
| rd_en_no | output | 1 | Active-low read enable for the result bus |
| result_o | output | DW | Last captured result |
| result_valid_o | output | 1 | One-cycle strobe for a new result |
| error_o | output | 1 | Sticky start-timeout or conversion-overrun flag |

## Verification
Each result has a fixed latency, counted at the sampling edges of the bench:
- `hold_o` follows `drdy_i` one sample later.
- The read enable falls one sample after the ready line is seen low.
- The valid strobe appears in the same sample in which the read enable is seen high again.
- The next start pulse appears ACQ_W samples after the ready line's fall.
- An error appears DR_WIN or MAX_W samples after the start pulse's rising edge.
- A retry appears ACQ_W samples after that error.

The bench drives the converter model only just after rising edges and samples only on falling edges. Each check compares a sample-counter difference against these exact figures, not against a window, so an off-by-one change to a counter is reported.

// File: rtl/sch_pkg.sv
package sch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PULSE, ST_WAIT_DR, ST_BUSY, ST_READ, ST_ACQ
  } sch_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sch_fsm.sv
module sch_fsm
  import sch_pkg::*;
#(
  parameter int CONV_W = 25,
  parameter int DR_WIN = 75,
  parameter int MAX_W  = 2000,
  parameter int READ_W = 4,
  parameter int ACQ_W  = 500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       drdy_i,
  output sch_state_e state_o,
  output logic       capture_o,
  output logic       fault_o
);
  localparam int TMAX = max2(max2(max2(CONV_W, DR_WIN), max2(MAX_W, READ_W)), ACQ_W);
  localparam int TW   = $clog2(TMAX + 1);

  sch_state_e st_q, st_d;
  logic [TW-1:0] t_q, t_d;
  logic seen_q, seen_d;

  always_comb begin
    st_d      = st_q;
    t_d       = t_q + 1'b1;
    seen_d    = seen_q;
    capture_o = 1'b0;
    fault_o   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        t_d = '0;
        if (enable_i) begin
          st_d   = ST_PULSE;
          seen_d = 1'b0;
        end
      end
      ST_PULSE: begin
        if (drdy_i) seen_d = 1'b1;
        if (t_q == TW'(CONV_W - 1))
          st_d = (seen_q || drdy_i) ? ST_BUSY : ST_WAIT_DR;
      end
      ST_WAIT_DR: begin
        if (drdy_i) st_d = ST_BUSY;
        else if (t_q == TW'(DR_WIN - 1)) begin
          fault_o = 1'b1;
          st_d    = ST_ACQ;
          t_d     = '0;
        end
      end
      ST_BUSY: begin
        if (!drdy_i) begin
          st_d = ST_READ;
          t_d  = '0;
        end else if (t_q == TW'(MAX_W - 1)) begin
          fault_o = 1'b1;
          st_d    = ST_ACQ;
          t_d     = '0;
        end
      end
      ST_READ: begin
        if (t_q == TW'(READ_W - 1)) begin
          capture_o = 1'b1;
          st_d      = ST_ACQ;
        end
      end
      ST_ACQ: begin
        // acquisition time counts only while the converter is idle
        if (drdy_i) t_d = '0;
        else if (t_q == TW'(ACQ_W - 1)) begin
          t_d    = '0;
          seen_d = 1'b0;
          st_d   = enable_i ? ST_PULSE : ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      t_q    <= '0;
      seen_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      t_q    <= t_d;
      seen_q <= seen_d;
    end
  end

  assign state_o = st_q;

  assert_fault_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fault_o && capture_o));
endmodule

// File: rtl/sch_capture.sv
module sch_capture #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          capture_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] result_o,
  output logic          valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= capture_i;
      if (capture_i) result_o <= data_i;
    end
  end

  assert_valid_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/conv_sched.sv
module conv_sched
  import sch_pkg::*;
#(
  parameter int DW     = 8,
  parameter int CONV_W = 25,
  parameter int DR_WIN = 75,
  parameter int MAX_W  = 2000,
  parameter int READ_W = 4,
  parameter int ACQ_W  = 500
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          drdy_i,
  input  logic [DW-1:0] data_i,
  output logic          convert_o,
  output logic          hold_o,
  output logic          rd_en_no,
  output logic [DW-1:0] result_o,
  output logic          result_valid_o,
  output logic          error_o
);
  localparam int TMAX = max2(max2(CONV_W, ACQ_W), 1);
  localparam int CW   = $clog2(TMAX + 2);

  sch_state_e st;
  logic capture, fault;

  sch_fsm #(
    .CONV_W(CONV_W), .DR_WIN(DR_WIN), .MAX_W(MAX_W), .READ_W(READ_W), .ACQ_W(ACQ_W)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .drdy_i(drdy_i),
    .state_o(st), .capture_o(capture), .fault_o(fault)
  );

  sch_capture #(.DW(DW)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .capture_i(capture), .data_i(data_i),
    .result_o(result_o), .valid_o(result_valid_o)
  );

  assign convert_o = (st == ST_PULSE);
  assign rd_en_no  = (st != ST_READ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o  <= 1'b0;
      error_o <= 1'b0;
    end else begin
      hold_o  <= drdy_i;
      error_o <= error_o | fault;
    end
  end

  // checker state
  logic          past_ok;
  logic [CW-1:0] hi_run, lo_run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_ok <= 1'b0;
      hi_run  <= '0;
      lo_run  <= CW'(ACQ_W);
    end else begin
      past_ok <= 1'b1;
      hi_run  <= convert_o ? ((hi_run == CW'(TMAX + 1)) ? hi_run : hi_run + 1'b1) : '0;
      lo_run  <= drdy_i ? '0 : ((lo_run == CW'(ACQ_W)) ? lo_run : lo_run + 1'b1);
    end
  end

  assert_conv_width_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(convert_o) |-> hi_run == CW'(CONV_W));
  assert_hold_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> hold_o == $past(drdy_i));
  assert_read_not_conv_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(convert_o && !rd_en_no));
  assert_acq_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(convert_o) |-> lo_run >= CW'(ACQ_W));
  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(error_o));
endmodule

// File: tb/sim_conv_sched.sv
`timescale 1ns/1ps
module sim_conv_sched;
  localparam int DW = 8, CONV_W = 25, DR_WIN = 75, MAX_W = 2000, READ_W = 4, ACQ_W = 500;
  localparam int DR_DLY = 10, CONV_LEN = 300;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, enable, dr;
  logic [DW-1:0] cur, data, res;
  logic conv, hold, rd_n, vld, err;
  assign data = rd_n ? '0 : cur;

  conv_sched #(.DW(DW), .CONV_W(CONV_W), .DR_WIN(DR_WIN), .MAX_W(MAX_W),
               .READ_W(READ_W), .ACQ_W(ACQ_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .drdy_i(dr), .data_i(data),
    .convert_o(conv), .hold_o(hold), .rd_en_no(rd_n), .result_o(res),
    .result_valid_o(vld), .error_o(err)
  );

  int errs = 0, checks = 0;
  logic [DW-1:0] exp_q[$];
  int mode = 0;  // 0 normal, 1 no ready rise, 2 overlong conversion
  int tx = 0, rx = 0, n_rise = 0, ncnt = 0, rise_at = 0, err_at = 0, drfall_at = 0;
  bit err_seen = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] code_of(input int i);
    if (i == 0) return '0;
    if (i == 1) return '1;
    return DW'(i * 53 + 7);
  endfunction

  // converter model and scoreboard driver
  initial begin
    dr = 1'b0; cur = '0;
    forever begin
      @(posedge clk); #1;
      if (conv) begin
        if (mode != 1) begin
          repeat (DR_DLY) @(posedge clk);
          #1 dr = 1'b1;
        end
        wait (conv == 1'b0);
        if (mode != 1) begin
          repeat ((mode == 2) ? MAX_W + 20 : CONV_LEN) @(posedge clk);
          #1;
          cur = code_of(tx);
          dr  = 1'b0;
          if (mode == 0) begin
            exp_q.push_back(cur);
            tx++;
          end
        end
      end
    end
  end

  // monitor
  bit p_dr, p_conv, p_rd, p_vld, p_err, pv, armed;
  int hi, lo, gap;
  always @(negedge clk) begin
    if (!rst_n) begin
      p_dr = 0; p_conv = 0; p_rd = 1; p_vld = 0; p_err = 0; pv = 0; armed = 0;
      hi = 0; lo = 0; gap = 0;
    end else begin
      ncnt++;
      if (pv) chk(hold == p_dr, "R2 hold", hold, p_dr);
      if (conv) hi++;
      else if (p_conv) begin
        chk(hi == CONV_W, "R1 pulse width", hi, CONV_W);
        hi = 0;
      end
      if (conv && !p_conv) begin
        n_rise++;
        rise_at = ncnt;
        if (armed) begin
          chk(gap == ACQ_W, "R5 acquisition gap", gap, ACQ_W);
          armed = 0;
        end
      end
      if (armed) gap++;
      if (!dr && p_dr) begin
        drfall_at = ncnt;
        if (enable) begin armed = 1; gap = 0; end
      end
      if (!rd_n) begin
        lo++;
        if (p_rd) begin
          chk(!dr && !conv, "R3 read while busy", int'(dr), 0);
          chk(ncnt - drfall_at == 1, "R3 read start", ncnt - drfall_at, 1);
        end
      end else if (!p_rd) begin
        chk(lo == READ_W, "R3 read width", lo, READ_W);
        lo = 0;
      end
      if (vld) begin
        chk(!p_vld, "R4 strobe width", int'(p_vld), 0);
        chk(rd_n && !p_rd, "R4 strobe timing", int'(p_rd), 0);
        if (exp_q.size() == 0) chk(0, "R4 unexpected result", res, -1);
        else begin
          automatic logic [DW-1:0] e = exp_q.pop_front();
          chk(res == e, "R4 result", res, e);
          rx++;
        end
      end
      if (err && !p_err) begin err_seen = 1; err_at = ncnt; end
      p_dr = dr; p_conv = conv; p_rd = rd_n; p_vld = vld; p_err = err; pv = 1;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; enable = 1'b0;
    repeat (3) @(negedge clk);
    chk(!conv && !hold && rd_n && !vld && !err, "R10 reset state",
        {conv, hold, rd_n, vld, err}, 5'b00100);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int nb, r0, txb;
    do_reset();
    // continuous run, then stop mid-conversion
    mode = 0;
    enable = 1'b1;
    wait (rx >= 4);
    wait (dr);
    @(negedge clk);
    enable = 1'b0;
    nb = n_rise;
    repeat (1500) @(negedge clk);
    chk(n_rise == nb, "R9 no start after disable", n_rise, nb);
    chk(rx == tx && rx == 5, "R9 in-flight result delivered", rx, 5);
    chk(!err, "R8 no error in normal run", int'(err), 0);

    // missing ready rise, then retry
    mode = 1; err_seen = 0; nb = n_rise;
    enable = 1'b1;
    wait (n_rise > nb);
    r0 = rise_at;
    wait (err_seen);
    chk(err_at - r0 == DR_WIN, "R6 start timeout", err_at - r0, DR_WIN);
    mode = 0; nb = n_rise; txb = tx;
    wait (n_rise > nb);
    chk(rise_at - err_at == ACQ_W, "R6 retry delay", rise_at - err_at, ACQ_W);
    @(negedge clk);
    enable = 1'b0;
    wait (rx == txb + 1);
    chk(err, "R8 sticky after retry", int'(err), 1);
    repeat (700) @(negedge clk);
    chk(err, "R8 still set", int'(err), 1);

    // overlong conversion
    do_reset();
    chk(!err, "R8 cleared by reset", int'(err), 0);
    mode = 2; err_seen = 0; nb = n_rise;
    enable = 1'b1;
    wait (n_rise > nb);
    @(negedge clk);
    enable = 1'b0;
    r0 = rise_at;
    wait (err_seen);
    chk(err_at - r0 == MAX_W, "R7 overrun timeout", err_at - r0, MAX_W);
    txb = rx;
    repeat (800) @(negedge clk);
    chk(rx == txb, "R7 no read after overrun", rx, txb);
    chk(n_rise == nb + 1, "R7 no restart while disabled", n_rise, nb + 1);
    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule